// File: doc/BRIEF.md
# Infix-to-Postfix Expression Converter

This block rewrites an arithmetic expression from infix order into postfix order, one byte at a time. Bytes arrive on a valid/ready input stream and leave on a valid/ready output stream. Operand bytes pass straight through. Operator and bracket codes are held on an internal operator stack and released in the order that precedence and associativity require. A terminator byte closes each expression. It empties the stack onto the output and is then forwarded itself, so that a downstream evaluator can run the postfix stream directly.

The converter never stops. A malformed expression (stack overflow, or brackets that do not pair up) sets a sticky error flag, and conversion carries on with the offending item dropped. A system reset clears the flag.

Top module: `expr_postfix_conv`

## Requirements
- R1: After reset, out_valid and err are low and in_ready is high for an operand byte.
- R2: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R3: A byte below 0x80 is an operand. It is presented on the output in the cycle after it is accepted, unchanged and in input order.
- R4: Operator codes are 0x80 add, 0x81 subtract, 0x82 multiply and 0x83 power. Power ranks above multiply, and multiply ranks above add and subtract, which rank equally. A stacked operator of higher rank is emitted before a lower-ranked incoming operator is stacked.
- R5: Add, subtract and multiply are left-associative: a stacked operator of equal rank is emitted before the incoming one is stacked.
- R6: Power is right-associative: an incoming 0x83 does not release a stacked 0x83.
- R7: 0x85 opens a group and 0x86 closes it. On a close, the operators stacked since the matching open are emitted newest first. Neither bracket code ever appears on the output.
- R8: On the terminator 0xFF, every stacked operator is emitted newest first, and then 0xFF itself is emitted.
- R9: The operator stack holds STACK_DEPTH entries (16 by default). A push onto a full stack sets err, and the pushed code is dropped.
- R10: A close bracket that finds no open bracket on the stack, or an open bracket still stacked when the terminator arrives, sets err. The stray bracket is discarded.
- R11: Once set, err stays high until reset, across later expressions.
- R12: Any other byte of 0x80 or above (0x84 and 0x87 through 0xFE) is accepted and dropped, with no output and no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Converter accepts the input byte this cycle |
| in_data | input | 8 | Infix byte: operand, operator, bracket or terminator |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Postfix byte |
| err | output | 1 | Sticky malformed-expression flag |

## Verification
The bench builds the converter with the default stack depth of 16. At that depth, a run of seventeen right-associative power operators overflows the stack, and so does a nest of seventeen open brackets, so the overflow path is checked as well as normal conversion. Random expressions are built with bracket nesting up to four deep. Stray codes are mixed in, and out_ready is throttled at random, so that stack pops are forced to wait on a stalled output and precedence releases overlap with backpressure.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam logic [7:0] CODE_ADD   = 8'h80;
  localparam logic [7:0] CODE_SUB   = 8'h81;
  localparam logic [7:0] CODE_MUL   = 8'h82;
  localparam logic [7:0] CODE_POW   = 8'h83;
  localparam logic [7:0] CODE_OPEN  = 8'h85;
  localparam logic [7:0] CODE_CLOSE = 8'h86;
  localparam logic [7:0] CODE_END   = 8'hFF;

  typedef enum logic [2:0] {
    K_OPND, K_OPER, K_OPEN, K_CLOSE, K_END, K_JUNK
  } kind_e;

  function automatic kind_e classify(logic [7:0] b);
    if (!b[7])                 return K_OPND;
    if (b[7:2] == 6'b100000)   return K_OPER;
    if (b == CODE_OPEN)        return K_OPEN;
    if (b == CODE_CLOSE)       return K_CLOSE;
    if (b == CODE_END)         return K_END;
    return K_JUNK;
  endfunction

  // binding strength of an operator code: add/sub 1, mul 2, pow 3
  function automatic logic [1:0] op_rank(logic [7:0] b);
    case (b[1:0])
      2'b10:   return 2'd2;
      2'b11:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/pfx_rst_sync.sv
module pfx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pfx_op_stack.sv
module pfx_op_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] top_idx;
  logic [W-1:0]  ent [DEPTH];
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + CW'(1);
    else if (do_pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (do_push && cnt_q == CW'(i)) slot_q <= din;
    end
    assign ent[i] = slot_q;
  end

  assign top_idx = cnt_q - CW'(1);
  assign top     = empty ? '0 : ent[top_idx[IW-1:0]];
endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (load)       valid_d = 1'b1;
    else if (ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) data <= din;
  end
endmodule

// File: rtl/expr_postfix_conv.sv
module expr_postfix_conv
  import pfx_pkg::*;
#(
  parameter int STACK_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       err
);
  logic       rst_q_n;
  logic [7:0] stk_top;
  logic       stk_empty, stk_full;
  logic       want_push, want_pop, want_emit, want_err, take;
  logic [7:0] emit_data;
  logic       out_free, top_open, top_wins;
  logic       err_d;
  kind_e      kind;

  pfx_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_q_n));

  assign out_free = !out_valid || out_ready;
  assign kind     = classify(in_data);
  assign top_open = !stk_empty && (stk_top == CODE_OPEN);
  // stacked operator must leave before the incoming one goes on
  assign top_wins = !stk_empty && !top_open &&
                    ((op_rank(stk_top) > op_rank(in_data)) ||
                     ((op_rank(stk_top) == op_rank(in_data)) && (in_data != CODE_POW)));

  always_comb begin
    take      = 1'b1;
    want_push = 1'b0;
    want_pop  = 1'b0;
    want_emit = 1'b0;
    want_err  = 1'b0;
    emit_data = in_data;
    case (kind)
      K_OPND: begin
        want_emit = 1'b1;
        take      = out_free;
      end
      K_OPER: begin
        if (top_wins) begin
          want_pop  = out_free;
          want_emit = 1'b1;
          emit_data = stk_top;
          take      = 1'b0;
        end else begin
          want_push = !stk_full;
          want_err  = stk_full;
        end
      end
      K_OPEN: begin
        want_push = !stk_full;
        want_err  = stk_full;
      end
      K_CLOSE: begin
        if (stk_empty) begin
          want_err = 1'b1;
        end else if (top_open) begin
          want_pop = 1'b1;
        end else begin
          want_pop  = out_free;
          want_emit = 1'b1;
          emit_data = stk_top;
          take      = 1'b0;
        end
      end
      K_END: begin
        if (stk_empty) begin
          want_emit = 1'b1;
          take      = out_free;
        end else if (top_open) begin
          want_pop = 1'b1;
          want_err = 1'b1;
          take     = 1'b0;
        end else begin
          want_pop  = out_free;
          want_emit = 1'b1;
          emit_data = stk_top;
          take      = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign in_ready = take;

  pfx_op_stack #(.DEPTH(STACK_DEPTH), .W(8)) u_stack (
    .clk   (clk),
    .rst_n (rst_q_n),
    .push  (in_valid && want_push),
    .pop   (in_valid && want_pop),
    .din   (in_data),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  pfx_out_stage #(.W(8)) u_out (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load  (in_valid && want_emit && out_free),
    .din   (emit_data),
    .ready (out_ready),
    .valid (out_valid),
    .data  (out_data)
  );

  assign err_d = err | (in_valid & want_err);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) err <= 1'b0;
    else          err <= err_d;
  end
endmodule

// File: rtl/expr_postfix_conv_chk.sv
module expr_postfix_conv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       err
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R2

  AST_OPND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_data[7] |=> out_valid && out_data == $past(in_data)); // R3

  AST_NO_BRACKET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != 8'h85 && out_data != 8'h86); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(in_valid) && $past(in_data[7])); // R10
endmodule

bind expr_postfix_conv expr_postfix_conv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .err       (err)
);

// File: tb/tb_expr_postfix_conv.sv
module tb_expr_postfix_conv;
  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       err;

  int  total = 0;
  int  bad = 0;
  int  cycles = 0;
  bit  stall_en = 1'b0;
  bit  finished = 1'b0;
  bq_t got;

  always #10 clk = ~clk;

  expr_postfix_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .err(err)
  );

  // output monitor: drive ready at falling edge, sample just before rising edge
  always begin
    @(negedge clk);
    out_ready = stall_en ? (($urandom % 10) < 7) : 1'b1;
    #8;
    if (rst_n && out_valid && out_ready) got.push_back(out_data);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int rank(logic [7:0] b);
    return (b == 8'h83) ? 3 : (b == 8'h82) ? 2 : 1;
  endfunction

  // reference conversion written from the requirements
  task automatic model(input bq_t src, output bq_t dst, output bit e);
    bq_t stk;
    dst = {};
    e = 1'b0;
    foreach (src[k]) begin
      logic [7:0] b = src[k];
      if (!b[7]) dst.push_back(b);
      else if (b >= 8'h80 && b <= 8'h83) begin
        while (stk.size() > 0 && stk[$] != 8'h85 &&
               (rank(stk[$]) > rank(b) || (rank(stk[$]) == rank(b) && b != 8'h83)))
          dst.push_back(stk.pop_back());
        if (stk.size() == 16) e = 1'b1; else stk.push_back(b);
      end else if (b == 8'h85) begin
        if (stk.size() == 16) e = 1'b1; else stk.push_back(b);
      end else if (b == 8'h86) begin
        while (stk.size() > 0 && stk[$] != 8'h85) dst.push_back(stk.pop_back());
        if (stk.size() > 0) void'(stk.pop_back()); else e = 1'b1;
      end else if (b == 8'hFF) begin
        while (stk.size() > 0) begin
          if (stk[$] == 8'h85) begin e = 1'b1; void'(stk.pop_back()); end
          else dst.push_back(stk.pop_back());
        end
        dst.push_back(8'hFF);
      end
    end
  endtask

  function automatic bq_t gen_expr();
    bq_t q;
    int depth = 0;
    int n = 1 + int'($urandom % 8);
    for (int i = 0; i < n; i++) begin
      while (depth < 4 && ($urandom % 4) == 0) begin q.push_back(8'h85); depth++; end
      q.push_back(8'($urandom % 128));
      while (depth > 0 && ($urandom % 3) == 0) begin q.push_back(8'h86); depth--; end
      if (($urandom % 10) == 0) q.push_back(8'(8'h87 + ($urandom % 8)));
      if (i < n - 1) q.push_back(8'(8'h80 + ($urandom % 4)));
    end
    while (depth > 0) begin q.push_back(8'h86); depth--; end
    q.push_back(8'hFF);
    return q;
  endfunction

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    forever begin
      #8;
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic run(input bq_t src, input bq_t exp, input bit exp_err, input string tag);
    bit same;
    int w;
    got = {};
    foreach (src[k]) send(src[k]);
    w = 0;
    while (got.size() < exp.size() && w < 400) begin @(negedge clk); w++; end
    repeat (6) @(negedge clk);
    same = (got.size() == exp.size());
    if (same) foreach (exp[k]) if (got[k] !== exp[k]) same = 1'b0;
    total++;
    if (!same) begin
      bad++;
      $display("FAIL %s stream: actual=%p expected=%p", tag, got, exp);
    end
    total++;
    if (err !== exp_err) begin
      bad++;
      $display("FAIL %s err: actual=%b expected=%b", tag, err, exp_err);
    end
  endtask

  task automatic run_model(input bq_t src, input string tag);
    bq_t exp;
    bit e;
    model(src, exp, e);
    run(src, exp, e, tag);
  endtask

  initial begin
    bq_t q;
    void'($urandom(32'd1234));
    do_reset();
    #8;
    total++;
    if (out_valid !== 1'b0 || err !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset: actual=%b%b%b expected=001", out_valid, err, in_ready);
    end

    // R3 R4: 3 + 4 * 2
    run('{8'h03, 8'h80, 8'h04, 8'h82, 8'h02, 8'hFF},
        '{8'h03, 8'h04, 8'h02, 8'h82, 8'h80, 8'hFF}, 1'b0, "R4 add-mul");
    // R4: 3 * 4 + 2
    run('{8'h03, 8'h82, 8'h04, 8'h80, 8'h02, 8'hFF},
        '{8'h03, 8'h04, 8'h82, 8'h02, 8'h80, 8'hFF}, 1'b0, "R4 mul-add");
    // R5: 8 - 3 - 2
    run('{8'h08, 8'h81, 8'h03, 8'h81, 8'h02, 8'hFF},
        '{8'h08, 8'h03, 8'h81, 8'h02, 8'h81, 8'hFF}, 1'b0, "R5 left");
    // R6: 2 ^ 3 ^ 2
    run('{8'h02, 8'h83, 8'h03, 8'h83, 8'h02, 8'hFF},
        '{8'h02, 8'h03, 8'h02, 8'h83, 8'h83, 8'hFF}, 1'b0, "R6 right");
    // R7: (1 + 2) * 3
    run('{8'h85, 8'h01, 8'h80, 8'h02, 8'h86, 8'h82, 8'h03, 8'hFF},
        '{8'h01, 8'h02, 8'h80, 8'h03, 8'h82, 8'hFF}, 1'b0, "R7 group");
    // R8: 1 + 2 * 3 ^ 4 flushed at terminator
    run('{8'h01, 8'h80, 8'h02, 8'h82, 8'h03, 8'h83, 8'h04, 8'hFF},
        '{8'h01, 8'h02, 8'h03, 8'h04, 8'h83, 8'h82, 8'h80, 8'hFF}, 1'b0, "R8 flush");
    // R12: stray codes dropped
    run('{8'h05, 8'h84, 8'h80, 8'h9A, 8'h06, 8'hFE, 8'hFF},
        '{8'h05, 8'h06, 8'h80, 8'hFF}, 1'b0, "R12 stray");

    // R10: unmatched close
    do_reset();
    run('{8'h01, 8'h86, 8'hFF}, '{8'h01, 8'hFF}, 1'b1, "R10 close");
    // R11: flag stays on a clean expression
    run('{8'h01, 8'h80, 8'h02, 8'hFF}, '{8'h01, 8'h02, 8'h80, 8'hFF}, 1'b1, "R11 sticky");
    // R10: open left at terminator
    do_reset();
    run('{8'h85, 8'h07, 8'h80, 8'h02, 8'hFF}, '{8'h07, 8'h02, 8'h80, 8'hFF}, 1'b1, "R10 open");

    // R9: seventeen powers overflow the 16-entry stack
    do_reset();
    q = {};
    for (int i = 0; i < 17; i++) begin q.push_back(8'h02); q.push_back(8'h83); end
    q.push_back(8'h02); q.push_back(8'hFF);
    run_model(q, "R9 pow overflow");
    // R9: sixteen powers fit exactly
    do_reset();
    q = {};
    for (int i = 0; i < 16; i++) begin q.push_back(8'h03); q.push_back(8'h83); end
    q.push_back(8'h03); q.push_back(8'hFF);
    run_model(q, "R9 pow full");
    // R9: bracket nest overflow
    do_reset();
    q = {};
    for (int i = 0; i < 17; i++) q.push_back(8'h85);
    q.push_back(8'h09);
    for (int i = 0; i < 17; i++) q.push_back(8'h86);
    q.push_back(8'hFF);
    run_model(q, "R9 nest overflow");

    // R2 R3 R4 R5 R6 R7 R8 R12: random expressions under backpressure
    do_reset();
    stall_en = 1'b1;
    for (int i = 0; i < 60; i++) run_model(gen_expr(), "R2 random");
    stall_en = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule